// File: doc/BRIEF.md
# Tiny-Result Flush and Flag Unit

This unit is the last stage of a single-precision floating-point pipeline. Upstream logic supplies a result that is already rounded for the normalized range. It arrives as a sign, a signed biased exponent and a 23-bit fraction, with an exactness bit. The unit also receives the two source operand words, the rounding mode, an execution-mode bit and a flush-quiet bit. It decides whether the result lies below the smallest normalized magnitude (2^-126). It also checks each operand for a denormal encoding.

In fast mode a tiny result becomes a signed zero or the signed smallest normal (minN), chosen by the rounding mode. A denormal operand is replaced by a signed zero. Both replacements raise a mapped indication unless flush-quiet is set. In precise mode the unit produces no replacement. A tiny result or a denormal operand raises a trap request, and software is then expected to emulate the operation.

All outputs are registered, with one cycle of latency, and a valid bit marks each result.

Top module: `fpfl_unit`

## Requirements
- R1: `out_valid` equals `in_valid` of the previous cycle. After reset every output is 0. A cycle with `in_valid`=0 yields all-zero data and flags.
- R2: In fast mode (`exec_precise`=0) a tiny result is replaced as follows. The sign is kept and the magnitude is either 0 or minN (0x00800000). The rounding mode `rnd_mode` is encoded as 00 to-nearest, 01 toward-zero, 10 toward-plus, 11 toward-minus.
  - To-nearest gives minN when the exponent is 0 (magnitude at least half of minN) and 0 when the exponent is below 0.
  - Toward-zero always gives 0.
  - Toward-plus gives minN only for a positive sign.
  - Toward-minus gives minN only for a negative sign.
- R3: A tiny result sets both `uf` and `ix`, even when `res_exact`=1.
- R4: `dmap` is 1 only in fast mode with `map_quiet`=0, and only when a tiny result or a denormal operand was replaced.
- R5: In fast mode a denormal operand is replaced by a signed zero. A denormal operand is one whose exponent field (bits 30:23) is 0 and whose fraction (bits 22:0) is nonzero. It is never replaced by minN. Zero and normal operands pass unchanged.
- R6: In precise mode a tiny result or a denormal operand sets `trap`. While `trap` is 1, `res_word` is 0 and the operands pass unchanged. `dmap` stays 0 whatever `map_quiet` is, and a tiny result still sets `uf` and `ix`.
- R7: A normal result is output as {sign, exponent[7:0], fraction}. When exact, `uf`=0 and `ix`=0. When inexact, only `ix`=1.
- R8: A result is tiny exactly when its signed exponent is 0 or less. An exponent of 1 is normal.
- R9: `trap` is never raised in fast mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input set is valid this cycle |
| res_sign | input | 1 | Result sign |
| res_exp | input | EXP_W | Signed biased result exponent |
| res_frac | input | 23 | Result fraction, hidden bit dropped |
| res_exact | input | 1 | Upstream result had no rounding error |
| rnd_mode | input | 2 | Rounding mode (see R2) |
| exec_precise | input | 1 | 1 precise mode, 0 fast mode |
| map_quiet | input | 1 | Suppress the mapped indication in fast mode |
| opa | input | 32 | Source operand A |
| opb | input | 32 | Source operand B |
| out_valid | output | 1 | Outputs valid |
| res_word | output | 32 | Final result word |
| opa_out | output | 32 | Operand A after flushing |
| opb_out | output | 32 | Operand B after flushing |
| uf | output | 1 | Underflow |
| ix | output | 1 | Inexact |
| dmap | output | 1 | A tiny value or denormal was replaced |
| trap | output | 1 | Emulation trap request |

## Verification
Some properties are checked on every cycle:
- valid alignment;
- that a mapped tiny result only ever carries a zero or minN magnitude;
- that underflow never appears without inexact;
- that a trap never leaves fast mode;
- that a mapped indication never shows with flush-quiet set or in precise mode;
- that a flushed denormal operand reads as a zero magnitude.

Other behaviour can only be shown by the bench's scenarios:
- which of zero or minN each rounding mode and sign selects;
- the exact-tiny inexact rule;
- the exponent boundary between 0 and 1;
- the precise-mode passthrough of operands.

// File: rtl/fpfl_pkg.sv
package fpfl_pkg;
    localparam int FRAC_W  = 23;
    localparam int EXPF_W  = 8;
    localparam int WORD_W  = 1 + EXPF_W + FRAC_W;
    localparam int NUM_OPS = 2;

    localparam logic [WORD_W-2:0] MIN_NORM_MAG = {{(EXPF_W-1){1'b0}}, 1'b1, {FRAC_W{1'b0}}};

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_ZERO = 2'b01,
        RM_UP   = 2'b10,
        RM_DOWN = 2'b11
    } rmode_e;

    typedef struct packed {
        logic                            valid;
        logic [WORD_W-1:0]               res;
        logic [NUM_OPS-1:0][WORD_W-1:0]  ops;
        logic                            uf;
        logic                            ix;
        logic                            dmap;
        logic                            trap;
    } stage_s;
endpackage

// File: rtl/fpfl_tiny_detect.sv
module fpfl_tiny_detect #(
    parameter int EXP_W = 10
) (
    input  logic signed [EXP_W-1:0] exp_i,
    output logic                    tiny_o,
    output logic                    upper_half_o
);
    logic exp_zero;

    always_comb begin
        exp_zero     = (exp_i == '0);
        // R8: negative or zero biased exponent is below 2^-126
        tiny_o       = exp_i[EXP_W-1] | exp_zero;
        // exponent 0 means magnitude in [2^-127, 2^-126)
        upper_half_o = exp_zero;
    end
endmodule

// File: rtl/fpfl_rm_select.sv
module fpfl_rm_select
    import fpfl_pkg::*;
(
    input  logic       sign_i,
    input  logic       upper_half_i,
    input  logic [1:0] rm_i,
    output logic       pick_min_o
);
    rmode_e rm;

    always_comb begin
        rm = rmode_e'(rm_i);
        unique case (rm)
            RM_NEAR: pick_min_o = upper_half_i;
            RM_ZERO: pick_min_o = 1'b0;
            RM_UP:   pick_min_o = ~sign_i;
            RM_DOWN: pick_min_o = sign_i;
            default: pick_min_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/fpfl_opnd_flush.sv
module fpfl_opnd_flush
    import fpfl_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output logic [WORD_W-1:0] word_o,
    output logic              is_den_o
);
    always_comb begin
        is_den_o = (word_i[WORD_W-2:FRAC_W] == '0) && (word_i[FRAC_W-1:0] != '0);
        word_o   = is_den_o ? {word_i[WORD_W-1], {(WORD_W-1){1'b0}}} : word_i;
    end
endmodule

// File: rtl/fpfl_unit.sv
module fpfl_unit
    import fpfl_pkg::*;
#(
    parameter int EXP_W = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    res_sign,
    input  logic signed [EXP_W-1:0] res_exp,
    input  logic [FRAC_W-1:0]       res_frac,
    input  logic                    res_exact,
    input  logic [1:0]              rnd_mode,
    input  logic                    exec_precise,
    input  logic                    map_quiet,
    input  logic [WORD_W-1:0]       opa,
    input  logic [WORD_W-1:0]       opb,
    output logic                    out_valid,
    output logic [WORD_W-1:0]       res_word,
    output logic [WORD_W-1:0]       opa_out,
    output logic [WORD_W-1:0]       opb_out,
    output logic                    uf,
    output logic                    ix,
    output logic                    dmap,
    output logic                    trap
);
    stage_s nxt_d, stg_q;
    logic   seen_q;

    logic tiny, upper_half, pick_min;
    logic [NUM_OPS-1:0][WORD_W-1:0] op_in, op_flush;
    logic [NUM_OPS-1:0]             op_den;

    assign op_in[0] = opa;
    assign op_in[1] = opb;

    fpfl_tiny_detect #(.EXP_W(EXP_W)) u_tiny (
        .exp_i        (res_exp),
        .tiny_o       (tiny),
        .upper_half_o (upper_half)
    );

    fpfl_rm_select u_rm (
        .sign_i       (res_sign),
        .upper_half_i (upper_half),
        .rm_i         (rnd_mode),
        .pick_min_o   (pick_min)
    );

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_opnd
        fpfl_opnd_flush u_flush (
            .word_i   (op_in[g]),
            .word_o   (op_flush[g]),
            .is_den_o (op_den[g])
        );
    end

    always_comb begin
        nxt_d       = '0;
        nxt_d.valid = in_valid;
        if (in_valid) begin
            if (!tiny) begin
                nxt_d.res = {res_sign, res_exp[EXPF_W-1:0], res_frac};
                nxt_d.ix  = ~res_exact;
            end else begin
                nxt_d.uf = 1'b1;
                nxt_d.ix = 1'b1;
                if (exec_precise) begin
                    nxt_d.trap = 1'b1;
                end else begin
                    nxt_d.res  = {res_sign, pick_min ? MIN_NORM_MAG : {(WORD_W-1){1'b0}}};
                    nxt_d.dmap = ~map_quiet;
                end
            end
            nxt_d.ops = exec_precise ? op_in : op_flush;
            if (|op_den) begin
                if (exec_precise) nxt_d.trap = 1'b1;
                else if (!map_quiet) nxt_d.dmap = 1'b1;
            end
            if (nxt_d.trap) nxt_d.res = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            stg_q  <= nxt_d;
            seen_q <= 1'b1;
        end
    end

    assign out_valid = stg_q.valid;
    assign res_word  = stg_q.res;
    assign opa_out   = stg_q.ops[0];
    assign opb_out   = stg_q.ops[1];
    assign uf        = stg_q.uf;
    assign ix        = stg_q.ix;
    assign dmap      = stg_q.dmap;
    assign trap      = stg_q.trap;

    assert_valid_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (out_valid == $past(in_valid)));

    assert_mapped_magnitude_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && uf && !trap) |->
        ((res_word[WORD_W-2:0] == '0) || (res_word[WORD_W-2:0] == MIN_NORM_MAG)));

    assert_uf_implies_ix_R3: assert property (@(posedge clk) disable iff (!rst_n)
        uf |-> ix);

    assert_dmap_cond_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && dmap) |-> (!$past(map_quiet) && !$past(exec_precise)));

    assert_op_flush_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && out_valid && !$past(exec_precise) &&
         $past(opa[WORD_W-2:FRAC_W] == '0) && $past(opa[FRAC_W-1:0] != '0))
        |-> (opa_out[WORD_W-2:0] == '0));

    assert_trap_res_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> (res_word == '0 && !dmap));

    assert_fast_no_trap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && trap) |-> $past(exec_precise));
endmodule

// File: tb/fpfl_unit_bench.sv
`timescale 1ns/1ps
module fpfl_unit_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, res_sign = 1'b0, res_exact = 1'b0;
    logic signed [9:0] res_exp = '0;
    logic [22:0] res_frac = '0;
    logic [1:0]  rnd_mode = '0;
    logic exec_precise = 1'b0, map_quiet = 1'b0;
    logic [31:0] opa = '0, opb = '0;
    logic out_valid, uf, ix, dmap, trap;
    logic [31:0] res_word, opa_out, opb_out;

    int total = 0;
    int bad = 0;
    logic [100:0] exq[$];
    string        tagq[$];

    always #5 clk = ~clk;

    fpfl_unit u_fpfl_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .res_sign(res_sign),
        .res_exp(res_exp), .res_frac(res_frac), .res_exact(res_exact),
        .rnd_mode(rnd_mode), .exec_precise(exec_precise), .map_quiet(map_quiet),
        .opa(opa), .opb(opb), .out_valid(out_valid), .res_word(res_word),
        .opa_out(opa_out), .opb_out(opb_out), .uf(uf), .ix(ix), .dmap(dmap), .trap(trap)
    );

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic bit is_den(logic [31:0] w);
        return (w[30:23] == 8'd0) && (w[22:0] != 23'd0);
    endfunction

    task automatic drive(string tag, bit v, bit s, int e, logic [22:0] f, bit ex,
                         logic [1:0] rm, bit pr, bit q, logic [31:0] a, logic [31:0] b);
        logic [31:0] er, ea, eb;
        bit euf, eix, edm, etr, mn;
        er = '0; ea = '0; eb = '0; euf = 0; eix = 0; edm = 0; etr = 0;
        if (v) begin
            if (e >= 1) begin
                er  = {s, e[7:0], f};
                eix = !ex;
            end else begin
                euf = 1; eix = 1;
                if (pr) etr = 1;
                else begin
                    case (rm)
                        2'b00:   mn = (e == 0);
                        2'b01:   mn = 0;
                        2'b10:   mn = !s;
                        default: mn = s;
                    endcase
                    er = mn ? {s, 31'h0080_0000} : {s, 31'h0};
                    if (!q) edm = 1;
                end
            end
            ea = (!pr && is_den(a)) ? {a[31], 31'h0} : a;
            eb = (!pr && is_den(b)) ? {b[31], 31'h0} : b;
            if (is_den(a) || is_den(b)) begin
                if (pr) etr = 1;
                else if (!q) edm = 1;
            end
            if (etr) er = '0;
        end
        @(negedge clk);
        in_valid = v; res_sign = s; res_exp = e[9:0]; res_frac = f; res_exact = ex;
        rnd_mode = rm; exec_precise = pr; map_quiet = q; opa = a; opb = b;
        exq.push_back({v, er, ea, eb, euf, eix, edm, etr});
        tagq.push_back(tag);
    endtask

    initial begin : monitor
        logic [100:0] x;
        string t;
        forever begin
            @(posedge clk);
            #1;
            if (exq.size() > 0) begin
                x = exq.pop_front();
                t = tagq.pop_front();
                chk(t, "valid", {31'b0, out_valid}, {31'b0, x[100]});
                chk(t, "res",   res_word, x[99:68]);
                chk(t, "opa",   opa_out,  x[67:36]);
                chk(t, "opb",   opb_out,  x[35:4]);
                chk(t, "uf",    {31'b0, uf},   {31'b0, x[3]});
                chk(t, "ix",    {31'b0, ix},   {31'b0, x[2]});
                chk(t, "dmap",  {31'b0, dmap}, {31'b0, x[1]});
                chk(t, "trap",  {31'b0, trap}, {31'b0, x[0]});
            end
        end
    end

    initial begin : watchdog
        #(200000 * 10);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1: reset state
        chk("R1", "rst valid", {31'b0, out_valid}, 32'd0);
        chk("R1", "rst res", res_word, 32'd0);
        chk("R1", "rst flags", {28'b0, uf, ix, dmap, trap}, 32'd0);

        // R7: normal results
        drive("R7", 1, 0, 100, 23'h123456, 1, 2'b00, 0, 0, 32'h3f80_0000, 32'h0);
        drive("R7", 1, 1, 254, 23'h7fffff, 0, 2'b01, 0, 0, 32'h0, 32'h4000_0000);
        // R8: boundary exponent 1 is normal, 0 is tiny
        drive("R8", 1, 0, 1, 23'h0, 1, 2'b00, 0, 0, 32'h0, 32'h0);
        drive("R8", 1, 0, 0, 23'h7fffff, 0, 2'b01, 0, 0, 32'h0, 32'h0);
        // R2: rounding-mode choice
        drive("R2", 1, 0, 0, 23'h100, 0, 2'b00, 0, 0, 32'h0, 32'h0);
        drive("R2", 1, 1, -1, 23'h100, 0, 2'b00, 0, 0, 32'h0, 32'h0);
        drive("R2", 1, 1, 0, 23'h100, 0, 2'b01, 0, 0, 32'h0, 32'h0);
        drive("R2", 1, 0, -5, 23'h3, 0, 2'b10, 0, 0, 32'h0, 32'h0);
        drive("R2", 1, 1, -5, 23'h3, 0, 2'b10, 0, 0, 32'h0, 32'h0);
        drive("R2", 1, 1, -9, 23'h3, 0, 2'b11, 0, 0, 32'h0, 32'h0);
        drive("R2", 1, 0, -9, 23'h3, 0, 2'b11, 0, 0, 32'h0, 32'h0);
        // R1: idle cycle between results
        drive("R1", 0, 1, 50, 23'h1, 0, 2'b00, 0, 0, 32'h1, 32'h1);
        // R3: exactly representable denormal still inexact
        drive("R3", 1, 0, -3, 23'h400000, 1, 2'b00, 0, 0, 32'h0, 32'h0);
        // R4: quiet flush suppresses mapped indication
        drive("R4", 1, 0, 0, 23'h0, 1, 2'b10, 0, 1, 32'h0, 32'h0);
        // R5: operand flushing
        drive("R5", 1, 0, 10, 23'h0, 1, 2'b00, 0, 0, 32'h0000_0001, 32'h8040_0000);
        drive("R5", 1, 0, 10, 23'h0, 1, 2'b10, 0, 1, 32'h807f_ffff, 32'h8000_0000);
        drive("R5", 1, 0, 10, 23'h0, 1, 2'b11, 0, 0, 32'h0080_0000, 32'h3f80_0000);
        // R9: fast mode with tiny and denormal never traps
        drive("R9", 1, 1, -20, 23'h5, 0, 2'b11, 0, 0, 32'h0000_0100, 32'h0);
        // R6: precise mode
        drive("R6", 1, 0, 0, 23'h7, 0, 2'b00, 1, 1, 32'h0, 32'h0);
        drive("R6", 1, 1, -2, 23'h7, 1, 2'b10, 1, 0, 32'h0, 32'h0);
        drive("R6", 1, 0, 77, 23'h1, 1, 2'b00, 1, 0, 32'h0000_0010, 32'h3f80_0000);
        drive("R6", 1, 0, 77, 23'h1, 0, 2'b00, 1, 0, 32'h3f80_0000, 32'h0);
        drive("R1", 0, 0, 0, 23'h0, 0, 2'b00, 0, 0, 32'h0, 32'h0);
        repeat (3) @(negedge clk);
        total++;
        if (exq.size() != 0) begin
            bad++;
            $display("FAIL R1 pending actual=%0d expected=0", exq.size());
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule